// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers and turns a segment choice plus a 16-bit offset into a 20-bit physical byte address. The segment base is moved up by four bit positions and the offset is added to it. Any carry beyond bit 19 is dropped, so addresses wrap inside a 1 MB space. Each segment covers a 64 KB window that starts at the byte its base points to. Segments may overlap, and different segment/offset pairs can name the same byte.

A client loads base registers through a write port and can read any of them back through a combinational read port. It asks for an address by raising a request strobe with a segment select and an offset. The address comes out of a register one clock later, together with a valid strobe. A base write made in the same cycle as a request only affects later requests.

Top module: `seg_addr_gen`

## Requirements
- R1: After synchronous reset the code base (select 01) reads FFFFh and the extra, stack and data bases (selects 00, 10, 11) read 0000h; the valid strobe is 0 and the address output is 00000h.
- R2: A write with the enable high loads the base picked by the write select at the clock edge, visible on the read-back port from the next cycle; the other three bases are unchanged.
- R3: The address output equals (base << 4) + offset, taken over 20 bits; base 1005h with offset 5555h gives 155A5h.
- R4: A carry out of bit 19 is discarded: base FFFFh with offset 0010h gives 00000h, and base FFFFh with offset FFFFh gives 0FFEFh.
- R5: Select encoding is 00 = extra, 01 = code, 10 = stack, 11 = data, the same on the write, read-back and request selects.
- R6: The valid strobe is high in the cycle after a request and low in the cycle after any cycle without one.
- R7: A request made in the same cycle as a write to its own segment uses the base value held before that write.
- R8: In a cycle after one without a request, the address output keeps its previous value.
- R9: Distinct base/offset pairs that sum to the same value give the same address (base 1000h + offset 0010h equals base 1001h + offset 0000h, both 10010h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load a segment base this cycle |
| wr_sel | input | 2 | Which base to load |
| wr_data | input | 16 | New base value |
| rd_sel | input | 2 | Which base to show on rd_data |
| rd_data | output | 16 | Current value of the selected base |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment used by the request |
| req_offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | Address output is fresh this cycle |
| addr_out | output | 20 | Registered physical byte address |

## Verification
The assertions assume that the selects and data are driven to known values whenever their strobes are high. They also assume that reset is held low for at least one clock edge before it is released, because the reset-value checks fire on its rising edge. The bench changes its inputs only on the falling edge and keeps the selects at defined values at all times. It sweeps every select against a set of bases and offsets that includes both ends of the range and the wrap points, so each check sees a settled base written in an earlier cycle, except in the one deliberate same-cycle write-and-request case.

// File: rtl/seg_addr_pkg.sv
// Package: shared constants and the segment select encoding for the
// segmented address generator. Assumes four segments and a 2-bit select.
package seg_addr_pkg;
    localparam int SEG_W    = 16;
    localparam int OFF_W    = 16;
    localparam int SHIFT    = 4;
    localparam int ADDR_W   = 20;
    localparam int NUM_SEG  = 4;
    localparam int SEL_W    = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_sel_e;

    // Reset value of base register idx: the code base starts at code_rst.
    function automatic logic [SEG_W-1:0] seg_reset_value(input int idx,
                                                         input logic [SEG_W-1:0] code_rst);
        return (idx == int'(SEG_CODE)) ? code_rst : '0;
    endfunction
endpackage

// File: rtl/seg_base_regs.sv
// Module: bank of segment base registers with one write port, one
// read-back port and one request read port. Assumes selects are in range
// (a power-of-two bank) and a synchronous active-low reset.
module seg_base_regs
    import seg_addr_pkg::*;
#(
    parameter int                 N_SEG    = NUM_SEG,
    parameter int                 B_W      = SEG_W,
    parameter logic [SEG_W-1:0]   CODE_RST = 16'hFFFF,
    localparam int                S_W      = $clog2(N_SEG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [S_W-1:0] wr_sel,
    input  logic [B_W-1:0] wr_data,
    input  logic [S_W-1:0] rd_sel,
    output logic [B_W-1:0] rd_data,
    input  logic [S_W-1:0] req_sel,
    output logic [B_W-1:0] req_base
);
    logic [B_W-1:0] base_q [N_SEG];

    genvar gi;
    generate
        for (gi = 0; gi < N_SEG; gi++) begin : g_base
            localparam logic [B_W-1:0] RST_VAL = B_W'(seg_reset_value(gi, CODE_RST));

            // Purpose: hold one base, reloaded when the write port targets it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q[gi] <= RST_VAL;
                else if (wr_en && (wr_sel == S_W'(gi)))
                    base_q[gi] <= wr_data;
            end

            // R1
            reset_value_chk: assert property (@(posedge clk)
                $rose(rst_n) |-> base_q[gi] == RST_VAL);

            // R2
            untouched_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_sel == S_W'(gi)) |=> $stable(base_q[gi]));
        end
    endgenerate

    // Purpose: combinational read-back of any base.
    always_comb rd_data = base_q[rd_sel];

    // Purpose: base feeding the address adder, before this cycle's write.
    always_comb req_base = base_q[req_sel];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/seg_addr_adder.sv
// Module: shifts a base left by SHIFT_N bits and adds a zero-extended
// offset, keeping only the low A_W bits (carry discarded, wrap-around).
// Assumes B_W + SHIFT_N <= A_W and O_W <= A_W.
module seg_addr_adder #(
    parameter int B_W     = 16,
    parameter int O_W     = 16,
    parameter int SHIFT_N = 4,
    parameter int A_W     = 20
) (
    input  logic [B_W-1:0] base,
    input  logic [O_W-1:0] offset,
    output logic [A_W-1:0] phys
);
    localparam int SH_W = B_W + SHIFT_N;

    logic [SH_W-1:0] shifted;

    // Purpose: place the base at its byte granularity.
    always_comb shifted = {base, {SHIFT_N{1'b0}}};

    // Purpose: modulo-2^A_W sum of shifted base and offset.
    always_comb phys = A_W'(shifted) + A_W'(offset);
endmodule

// File: rtl/seg_addr_outreg.sv
// Module: output stage; captures the address on a request and raises a
// one-cycle valid, holding the address between requests.
// Assumes synchronous active-low reset.
module seg_addr_outreg #(
    parameter int A_W = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] addr_in,
    output logic           valid_q,
    output logic [A_W-1:0] addr_q
);
    // Purpose: valid strobe follows the request by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= load;
    end

    // Purpose: capture the address only when a request is present.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_in;
    end

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_q));
endmodule

// File: rtl/seg_addr_gen.sv
// Module: top of the segmented physical address generator. Four base
// registers, a shift-and-add address former and a registered output.
// Assumes selects and data are known whenever their strobes are high.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [SEG_W-1:0]  rd_data,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out
);
    logic [SEG_W-1:0]  sel_base;
    logic [ADDR_W-1:0] next_addr;

    seg_base_regs #(
        .N_SEG    (NUM_SEG),
        .B_W      (SEG_W),
        .CODE_RST (CODE_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .req_sel  (req_sel),
        .req_base (sel_base)
    );

    seg_addr_adder #(
        .B_W     (SEG_W),
        .O_W     (OFF_W),
        .SHIFT_N (SHIFT),
        .A_W     (ADDR_W)
    ) u_adder (
        .base   (sel_base),
        .offset (req_offset),
        .phys   (next_addr)
    );

    seg_addr_outreg #(
        .A_W (ADDR_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (req_valid),
        .addr_in (next_addr),
        .valid_q (addr_valid),
        .addr_q  (addr_out)
    );

    // R6
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    // R6
    idle_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    // R3 (and R7: base sampled is the pre-write value)
    addr_formula_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_out ==
            (ADDR_W'({$past(sel_base), {SHIFT{1'b0}}}) + ADDR_W'($past(req_offset))));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!addr_valid && addr_out == '0));
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [1:0]  rd_sel;
    logic [15:0] rd_data;
    logic        req_valid;
    logic [1:0]  req_sel;
    logic [15:0] req_offset;
    logic        addr_valid;
    logic [19:0] addr_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [15:0] model [4];

    always #4 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .req_valid(req_valid), .req_sel(req_sel), .req_offset(req_offset),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    function automatic logic [19:0] expect_addr(input logic [15:0] b, input logic [15:0] o);
        int unsigned s;
        s = (int'(b) * 16) + int'(o);
        return 20'(s % (1 << 20));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_base(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[s] = v;
    endtask

    task automatic readback_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #1;
            chk(tag, 32'(rd_data), 32'(model[i]));
        end
    endtask

    // Issue one request; check the result the next cycle, then idle/hold.
    task automatic request(input logic [1:0] s, input logic [15:0] o, input string tag);
        logic [19:0] e;
        e = expect_addr(model[s], o);
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_offset = o;
        @(negedge clk);
        req_valid = 1'b0; req_offset = ~o;
        chk({tag, " R6 valid"}, 32'(addr_valid), 32'd1);
        chk(tag, 32'(addr_out), 32'(e));
        @(negedge clk);
        chk("R6 idle valid low", 32'(addr_valid), 32'd0);
        chk("R8 hold address", 32'(addr_out), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [5];
        logic [15:0] offs [6];
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_sel = '0; req_valid = 1'b0; req_sel = '0; req_offset = '0;
        model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000; model[3] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        readback_all("R1 reset base");
        chk("R1 reset valid", 32'(addr_valid), 32'd0);
        chk("R1 reset address", 32'(addr_out), 32'd0);

        // R3 worked example on the code slot (select 01, R5)
        write_base(2'b01, 16'h1005);
        request(2'b01, 16'h5555, "R3 example");
        chk("R3 example literal", 32'(expect_addr(16'h1005, 16'h5555)), 32'h155A5);

        // R4 wrap points
        write_base(2'b11, 16'hFFFF);
        request(2'b11, 16'h0010, "R4 wrap to zero");
        chk("R4 literal zero", 32'(expect_addr(16'hFFFF, 16'h0010)), 32'h00000);
        request(2'b11, 16'hFFFF, "R4 wrap top");
        chk("R4 literal top", 32'(expect_addr(16'hFFFF, 16'hFFFF)), 32'h0FFEF);

        // R5 distinct bases per select, offset zero shows which base is used
        write_base(2'b00, 16'h0A00);
        write_base(2'b01, 16'h0B00);
        write_base(2'b10, 16'h0C00);
        write_base(2'b11, 16'h0D00);
        readback_all("R5 readback map");
        request(2'b00, 16'h0000, "R5 extra 00");
        chk("R5 extra literal", 32'(addr_out), 32'h0A000);
        request(2'b01, 16'h0000, "R5 code 01");
        chk("R5 code literal", 32'(addr_out), 32'h0B000);
        request(2'b10, 16'h0000, "R5 stack 10");
        chk("R5 stack literal", 32'(addr_out), 32'h0C000);
        request(2'b11, 16'h0000, "R5 data 11");
        chk("R5 data literal", 32'(addr_out), 32'h0D000);

        // R2/R3 sweep: every select, several bases and offsets
        bases[0] = 16'h0000; bases[1] = 16'hFFFF; bases[2] = 16'h1005;
        bases[3] = 16'h8000; bases[4] = 16'h0000;
        offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h5555;
        offs[3] = 16'hFFFF; offs[4] = 16'h0010; offs[5] = 16'h8000;
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 5; b++) begin
                logic [15:0] v;
                v = (b == 4) ? 16'(16'h1234 * (s + 1)) : bases[b];
                write_base(2'(s), v);
                readback_all("R2 write and others unchanged");
                for (int o = 0; o < 6; o++)
                    request(2'(s), offs[o], "R3 sweep address");
            end
        end

        // R7 same-cycle write and request to the same segment
        write_base(2'b10, 16'h2000);
        @(negedge clk);
        req_valid = 1'b1; req_sel = 2'b10; req_offset = 16'h0004;
        wr_en = 1'b1; wr_sel = 2'b10; wr_data = 16'h3000;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk("R7 uses old base", 32'(addr_out), 32'h20004);
        model[2] = 16'h3000;
        request(2'b10, 16'h0004, "R7 next uses new base");
        chk("R7 new literal", 32'(addr_out), 32'h30004);

        // R9 aliasing
        write_base(2'b00, 16'h1000);
        write_base(2'b01, 16'h1001);
        request(2'b00, 16'h0010, "R9 alias first");
        chk("R9 alias literal a", 32'(addr_out), 32'h10010);
        request(2'b01, 16'h0000, "R9 alias second");
        chk("R9 alias literal b", 32'(addr_out), 32'h10010);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule